// File: doc/BRIEF.md
# Two-Stage I/Q Decimation Chain

This block brings the 3-bit words from a pair of sigma-delta modulators, one for the in-phase path and one for the quadrature path, down to the symbol-rate sample stream. It runs on the system clock and takes one new word per channel on each cycle where the sample enable is high. The enable marks the modulator rate, nominally 6.5 MHz. Each path has two stages. The first is a fourth-order cascaded integrator-comb (sinc) filter that divides the rate by 6, to about 1.08 MHz. The second is a symmetric 24-tap low-pass FIR that divides the rate by 4, to about 270.8 kHz. The FIR works out only the samples it keeps, and it does so with one multiply-accumulate unit per path.

The two paths run in lockstep and share one output strobe. Each output word is signed, 16 bits wide, rounded and saturated from the full-precision accumulator. A synchronous reset clears all filter history, so the first outputs after reset are computed as though every earlier input were zero.

Top module: `iq_decim24`

## Requirements
- R1: `smp_i` and `smp_q` are signed 3-bit two's-complement values (-4 to 3). They are taken only on cycles where `smp_en` is high. Their values on other cycles have no effect on any output.
- R2: The sinc stage emits one value for each group of 6 accepted samples. With accepted samples numbered x[0], x[1], ... from reset, value k is the sum of h[n]·x[6k+5−n]. Here h (21 taps, sum 1296) is a 6-sample all-ones window convolved with itself four times. Its state wraps in two's complement on 14 bits.
- R3: FIR tap j, for j = 0..23, has the weight (j+1)·(24−j). This gives a symmetric low-pass with weights summing to 2600.
- R4: One output strobe occurs for every 24 accepted samples. With sinc values y[0], y[1], ..., output m is formed from z = sum of c[j]·y[4m+3−j], where y at a negative index counts as 0.
- R5: The output word is floor((z + 128) / 256), that is, rounding half upward at a shift of 8 bits.
- R6: A rounded result above 32767 is output as 32767, and one below −32768 is output as −32768.
- R7: The I and Q results appear on the same strobe, and each depends only on its own channel's inputs.
- R8: A synchronous reset drives `out_vld` low and both output words to 0. It clears all integrator, comb, delay-line and accumulator state.
- R9: `out_vld` is high for exactly one clock cycle per result.
- R10: Results are the same whether `smp_en` is high on every cycle or only on some cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | Modulator-rate sample enable |
| smp_i | input | 3 | In-phase modulator word, signed |
| smp_q | input | 3 | Quadrature modulator word, signed |
| out_vld | output | 1 | One-cycle strobe for a new result pair |
| out_i | output | 16 | Filtered in-phase word, signed |
| out_q | output | 16 | Filtered quadrature word, signed |

## Verification
Opposite constant levels on I and Q (+1 and −1) check the step response of both stages, and they also expose any mixing between the channels. Full-scale constants (+3 and −4) drive both saturation limits. An input that alternates every sample sits at the null of the sinc stage, which separates a correct comb from one with a wrong delay. Pseudo-random words, both at the full enable rate and with gaps filled by junk data, check the exact decimation phase and the rounding. They also check that words on disabled cycles are ignored. A reset in the middle of the stream, followed by fresh data, shows whether any history survives the reset.

// File: rtl/iq_decim_pkg.sv
package iq_decim_pkg;
  localparam int NUM_CH = 2;

  // bits needed by a sinc filter: input width plus log2 of its DC gain
  function automatic int cic_width(input int in_w, input int order, input int ratio);
    return in_w + $clog2(ratio ** order);
  endfunction

  // signed width holding the largest weight (j+1)(taps-j)
  function automatic int coef_width(input int taps);
    return $clog2((taps / 2) * (taps / 2 + 1) + 1) + 1;
  endfunction
endpackage

// File: rtl/iq_cic_decim.sv
module iq_cic_decim #(
  parameter int IN_W  = 3,
  parameter int ORDER = 4,
  parameter int RATIO = 6,
  parameter int OUT_W = 14
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ce,
  input  logic signed [IN_W-1:0]  din,
  output logic                    vld,
  output logic signed [OUT_W-1:0] dout
);
  localparam int PW = $clog2(RATIO);

  logic [PW-1:0] phase;
  logic signed [OUT_W-1:0] integ    [ORDER];
  logic signed [OUT_W-1:0] integ_nx [ORDER];
  logic signed [OUT_W-1:0] dly      [ORDER];
  logic signed [OUT_W-1:0] comb_nx  [ORDER];
  logic dec_tick;
  logic signed [OUT_W-1:0] integ_head;

  assign dec_tick   = ce && (phase == PW'(RATIO - 1));
  assign integ_head = integ[0];

  always_comb begin
    integ_nx[0] = integ[0] + OUT_W'(din);
    for (int k = 1; k < ORDER; k++) integ_nx[k] = integ[k] + integ_nx[k-1];
    comb_nx[0] = integ_nx[ORDER-1] - dly[0];
    for (int k = 1; k < ORDER; k++) comb_nx[k] = comb_nx[k-1] - dly[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      vld   <= 1'b0;
      dout  <= '0;
      for (int k = 0; k < ORDER; k++) begin
        integ[k] <= '0;
        dly[k]   <= '0;
      end
    end else begin
      vld <= dec_tick;
      if (ce) begin
        integ <= integ_nx;
        phase <= dec_tick ? '0 : phase + 1'b1;
      end
      if (dec_tick) begin
        dly[0] <= integ_nx[ORDER-1];
        for (int k = 1; k < ORDER; k++) dly[k] <= comb_nx[k-1];
        dout <= comb_nx[ORDER-1];
      end
    end
  end

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst) !ce |=> $stable(integ_head));
  // R2
  tick_after_ce_chk: assert property (@(posedge clk) disable iff (rst) vld |-> $past(ce));
  // R2
  tick_single_chk: assert property (@(posedge clk) disable iff (rst) vld |=> !vld);
endmodule

// File: rtl/iq_fir_decim.sv
module iq_fir_decim #(
  parameter int IN_W  = 14,
  parameter int TAPS  = 24,
  parameter int RATIO = 4,
  parameter int OUT_W = 16,
  parameter int SHIFT = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_vld,
  input  logic signed [IN_W-1:0]  din,
  output logic                    out_vld,
  output logic signed [OUT_W-1:0] dout
);
  import iq_decim_pkg::*;

  localparam int HALF = TAPS / 2;
  localparam int CW   = coef_width(TAPS);
  localparam int IW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int PH_W = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam int AW   = IN_W + 1 + CW + IW + 1;
  localparam logic signed [AW-1:0] MAXV = AW'((64'sd1 <<< (OUT_W - 1)) - 1);
  localparam logic signed [AW-1:0] MINV = ~MAXV;

  function automatic logic signed [CW-1:0] coef(input logic [IW-1:0] j);
    return CW'((int'(j) + 1) * (TAPS - int'(j)));
  endfunction

  function automatic logic signed [OUT_W-1:0] round_sat(input logic signed [AW-1:0] a);
    logic signed [AW-1:0] half, r;
    half = AW'(1) << (SHIFT - 1);
    r    = (a + half) >>> SHIFT;
    if (r > MAXV) r = MAXV;
    if (r < MINV) r = MINV;
    return OUT_W'(r);
  endfunction

  logic signed [IN_W-1:0] line    [TAPS];
  logic signed [IN_W-1:0] line_nx [TAPS];
  logic signed [IN_W-1:0] shadow  [TAPS];
  logic [PH_W-1:0] phase;
  logic [IW-1:0]   idx;
  logic            busy, start, last;
  logic signed [IN_W:0]   presum;
  logic signed [AW-1:0]   prod, acc, acc_nx;

  assign start = in_vld && (phase == PH_W'(RATIO - 1));
  assign last  = busy && (idx == IW'(HALF - 1));

  always_comb begin
    line_nx[0] = din;
    for (int k = 1; k < TAPS; k++) line_nx[k] = line[k-1];
    presum = (IN_W+1)'(shadow[idx]) + (IN_W+1)'(shadow[TAPS-1-int'(idx)]);
    prod   = AW'(presum) * AW'(coef(idx));
    acc_nx = acc + prod;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= '0;
      idx     <= '0;
      busy    <= 1'b0;
      acc     <= '0;
      out_vld <= 1'b0;
      dout    <= '0;
      for (int k = 0; k < TAPS; k++) begin
        line[k]   <= '0;
        shadow[k] <= '0;
      end
    end else begin
      out_vld <= last;
      if (last) dout <= round_sat(acc_nx);
      if (in_vld) begin
        line  <= line_nx;
        phase <= start ? '0 : phase + 1'b1;
      end
      if (start) begin
        shadow <= line_nx;
        busy   <= 1'b1;
        idx    <= '0;
        acc    <= '0;
      end else if (busy) begin
        acc <= acc_nx;
        idx <= idx + 1'b1;
        if (last) busy <= 1'b0;
      end
    end
  end

  // R10
  mac_free_chk: assert property (@(posedge clk) disable iff (rst) start |-> !busy);
  // R9
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst) out_vld |=> !out_vld);
  // R4
  strobe_after_mac_chk: assert property (@(posedge clk) disable iff (rst) out_vld |-> $past(busy));
endmodule

// File: rtl/iq_decim24.sv
module iq_decim24 #(
  parameter int IN_W      = 3,
  parameter int CIC_ORDER = 4,
  parameter int CIC_RATIO = 6,
  parameter int FIR_RATIO = 4,
  parameter int FIR_TAPS  = 24,
  parameter int OUT_W     = 16,
  parameter int OUT_SHIFT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_en,
  input  logic [IN_W-1:0]  smp_i,
  input  logic [IN_W-1:0]  smp_q,
  output logic             out_vld,
  output logic [OUT_W-1:0] out_i,
  output logic [OUT_W-1:0] out_q
);
  import iq_decim_pkg::*;

  localparam int MID_W = cic_width(IN_W, CIC_ORDER, CIC_RATIO);

  logic signed [IN_W-1:0]  smp_arr [NUM_CH];
  logic signed [MID_W-1:0] mid_arr [NUM_CH];
  logic signed [OUT_W-1:0] res_arr [NUM_CH];
  logic mid_vld [NUM_CH];
  logic ch_vld  [NUM_CH];

  assign smp_arr[0] = smp_i;
  assign smp_arr[1] = smp_q;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_path
    iq_cic_decim #(
      .IN_W(IN_W), .ORDER(CIC_ORDER), .RATIO(CIC_RATIO), .OUT_W(MID_W)
    ) u_cic (
      .clk(clk), .rst(rst), .ce(smp_en), .din(smp_arr[ch]),
      .vld(mid_vld[ch]), .dout(mid_arr[ch])
    );
    iq_fir_decim #(
      .IN_W(MID_W), .TAPS(FIR_TAPS), .RATIO(FIR_RATIO), .OUT_W(OUT_W), .SHIFT(OUT_SHIFT)
    ) u_fir (
      .clk(clk), .rst(rst), .in_vld(mid_vld[ch]), .din(mid_arr[ch]),
      .out_vld(ch_vld[ch]), .dout(res_arr[ch])
    );
  end

  assign out_vld = ch_vld[0];
  assign out_i   = res_arr[0];
  assign out_q   = res_arr[1];

  // R7
  iq_lockstep_chk: assert property (@(posedge clk) disable iff (rst) ch_vld[0] == ch_vld[1]);
  // R8
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!out_vld && out_i == '0 && out_q == '0));
endmodule

// File: tb/test_iq_decim24.sv
module test_iq_decim24;
  localparam int CLK_PERIOD = 10;
  localparam int TAPS = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_en = 1'b0;
  logic [2:0] smp_i = '0;
  logic [2:0] smp_q = '0;
  logic out_vld;
  logic [15:0] out_i, out_q;

  always #(CLK_PERIOD/2) clk = ~clk;

  iq_decim24 i_iq_decim24 (
    .clk(clk), .rst(rst), .smp_en(smp_en), .smp_i(smp_i), .smp_q(smp_q),
    .out_vld(out_vld), .out_i(out_i), .out_q(out_q)
  );

  int total = 0;
  int bad = 0;
  longint hbox [21];
  longint xs [2][8192];
  longint ys [2][2048];
  int nx = 0;
  int ny = 0;
  longint expi [$];
  longint expq [$];
  logic [15:0] lfsr = 16'hACE1;
  bit prev_vld = 1'b0;

  task automatic check(input bit ok, input string req, input longint got, input longint want);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, want);
    end
  endtask

  // R5 R6: floor((z+128)/256) then clamp
  function automatic longint scale_out(input longint z);
    longint r;
    r = z + 128;
    if (r >= 0) r = r / 256;
    else r = -((-r + 255) / 256);
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic model_push(input int a, input int b);
    xs[0][nx] = a;
    xs[1][nx] = b;
    nx++;
    if (nx % 6 == 0) begin
      int k = nx / 6 - 1;
      for (int ch = 0; ch < 2; ch++) begin
        longint y = 0;
        for (int n = 0; n < 21; n++)
          if (6 * k + 5 - n >= 0) y += hbox[n] * xs[ch][6 * k + 5 - n];
        ys[ch][ny] = y;
      end
      ny++;
      if (ny % 4 == 0) begin
        int m = ny / 4 - 1;
        longint z [2];
        for (int ch = 0; ch < 2; ch++) begin
          z[ch] = 0;
          for (int j = 0; j < TAPS; j++)
            if (4 * m + 3 - j >= 0) z[ch] += longint'((j + 1) * (TAPS - j)) * ys[ch][4 * m + 3 - j];
        end
        expi.push_back(scale_out(z[0]));
        expq.push_back(scale_out(z[1]));
      end
    end
  endtask

  task automatic feed(input int a, input int b);
    @(negedge clk);
    smp_en = 1'b1;
    smp_i = 3'(a);
    smp_q = 3'(b);
    model_push(a, b);
  endtask

  // R1: junk on the data pins while the enable is low
  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      smp_en = 1'b0;
      smp_i = lfsr[2:0];
      smp_q = lfsr[5:3];
      lfsr = lfsr_next(lfsr);
    end
  endtask

  task automatic feed_random(input int n, input bit sparse);
    for (int s = 0; s < n; s++) begin
      int a, b;
      a = $signed(lfsr[2:0]);
      b = $signed(lfsr[7:5]);
      lfsr = lfsr_next(lfsr);
      feed(a, b);
      if (sparse) idle(1 + int'(lfsr[1:0]) % 3);
    end
  endtask

  // scoreboard monitor: R4 R5 R6 R7 R9
  always @(negedge clk) begin
    if (!rst && out_vld) begin
      check(!prev_vld, "R9 strobe longer than one cycle", 1, 0);
      if (expi.size() == 0) begin
        check(1'b0, "R4 unexpected strobe", 1, 0);
      end else begin
        longint ei, eq;
        ei = expi.pop_front();
        eq = expq.pop_front();
        check(longint'($signed(out_i)) == ei, "R4 R5 R6 R7 I word", longint'($signed(out_i)), ei);
        check(longint'($signed(out_q)) == eq, "R4 R5 R6 R7 Q word", longint'($signed(out_q)), eq);
      end
    end
    prev_vld = out_vld;
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R2: impulse response of four cascaded 6-sample windows
    longint tmp [21];
    for (int i = 0; i < 21; i++) hbox[i] = (i == 0) ? 1 : 0;
    repeat (4) begin
      for (int i = 0; i < 21; i++) begin
        tmp[i] = 0;
        for (int t = 0; t < 6; t++) if (i - t >= 0) tmp[i] += hbox[i - t];
      end
      for (int i = 0; i < 21; i++) hbox[i] = tmp[i];
    end

    repeat (4) @(negedge clk);
    // R8 reset state
    check(out_vld == 1'b0, "R8 strobe in reset", longint'(out_vld), 0);
    check(out_i == '0 && out_q == '0, "R8 words in reset", longint'(out_i), 0);
    rst = 1'b0;

    // R2 R3 R7: opposite constant levels
    for (int s = 0; s < 96; s++) feed(1, -1);
    idle(40);
    // R6: both saturation limits
    for (int s = 0; s < 96; s++) feed(3, -4);
    idle(40);
    // R4 R5: random words, enable every cycle
    feed_random(240, 1'b0);
    idle(40);
    // R1 R10: random words with junk-filled gaps
    feed_random(144, 1'b1);
    idle(40);

    // R8: reset in mid-run clears history
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(out_vld == 1'b0, "R8 strobe after reset", longint'(out_vld), 0);
    check(out_i == '0 && out_q == '0, "R8 words after reset", longint'(out_i), 0);
    check(expi.size() == 0, "R4 results pending before reset", expi.size(), 0);
    nx = 0;
    ny = 0;
    rst = 1'b0;

    // R2: alternating input at the sinc null
    for (int s = 0; s < 96; s++) feed((s % 2) ? 3 : -4, (s % 2) ? -4 : 3);
    idle(40);

    check(expi.size() == 0, "R4 missing results", expi.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule